// File: doc/BRIEF.md
# Chip-Select Wait-State Stall Controller

This block stretches CPU bus cycles so that slow external devices have time to finish a read or write. It drives four active-low chip-select lines. An external decoder supplies a per-cycle hit vector, and an access starts when that vector has a bit set, IORQ is low and either RD or WR is low. The block then lowers the matching chip select and raises a stall signal toward the CPU for as many clocks as the selected chip select's programmed wait count.

Each chip select owns an 8-bit control register written through a simple write port. Bits [7:5] of that register hold the wait count (0 to 7). The external WAIT pin is active low and passes through one flip-flop on the system clock. Once the programmed wait count has run out, the stall follows that registered WAIT value. Because of this, WAIT is only honoured on a chip select that has at least one programmed wait state. The chip select and the stall both drop in the cycle after RD and WR have both returned high.

Top module: `wst_stall_ctrl`

## Requirements
- R1: After reset, all `cs_n` bits are high, `stall` is low, and every control register holds zero, so an access takes no wait states even while `wait_n` is held low.
- R2: When no access is in progress and `iorq_n` is low, and `rd_n` or `wr_n` is low, and `cs_hit` is non-zero, the chip select `cs_n[k]` goes low in the next cycle and it is the only low bit. Here k is the lowest set bit of `cs_hit`.
- R3: A write with `reg_we` high stores `reg_wdata[7:5]` as the wait count of the chip select indexed by `reg_sel` (0 to 3). The other data bits have no effect on the count.
- R4: With a wait count W > 0 and `wait_n` held high, `stall` is high for exactly W consecutive cycles, starting in the cycle in which the chip select goes low.
- R5: With a wait count of 0, `stall` stays low for the whole access, whatever the level of `wait_n`.
- R6: With W > 0, once the W programmed cycles have passed, `stall` equals the inverse of `wait_n` as sampled at the previous clock edge. The stall ends in the first cycle after a clock edge that samples `wait_n` high.
- R7: In the cycle after a clock edge at which both `rd_n` and `wr_n` are high during an access, all `cs_n` bits are high and `stall` is low.
- R8: While an access is in progress, changes to `cs_hit` are ignored and the asserted chip select stays the same. A new access never starts while `stall` is high.
- R9: When `iorq_n` is high, no chip select is asserted, even if `cs_hit`, `rd_n` or `wr_n` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_hit | input | 4 | Per-cycle decoder hit vector, one bit per chip select |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wait_n | input | 1 | External WAIT pin, active low |
| reg_we | input | 1 | Control register write enable |
| reg_sel | input | 2 | Index of the control register to write |
| reg_wdata | input | 8 | Control register write data; bits [7:5] hold the wait count |
| cs_n | output | 4 | Chip-select lines, active low |
| stall | output | 1 | CPU stall request, active high |

## Verification
The assertions assume that the CPU keeps RD or WR low for as long as `stall` is high. They also assume that `wait_n` has a defined level from the first clock edge after reset. The bench ends each access only after it has seen `stall` low, so it never ends an access early. It drives `wait_n` low only from the start of an access until it has counted the stall cycles it intends to produce. Hit vectors with several bits set are allowed, and priority resolves them.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned WAIT_LSB = 5;
  localparam int unsigned WAIT_W   = 3;

  typedef enum logic {PH_IDLE = 1'b0, PH_BUSY = 1'b1} phase_t;
endpackage

// File: rtl/wst_cfg_regs.sv
module wst_cfg_regs #(
  parameter int unsigned NUM_CS   = 4,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned WAIT_LSB = 5,
  parameter int unsigned WAIT_W   = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [SEL_W-1:0]               sel,
  input  logic [CTRL_W-1:0]              wdata,
  output logic [NUM_CS-1:0][WAIT_W-1:0]  waits
);
  localparam logic [CTRL_W-1:0] FIELD_MASK = ((CTRL_W'(1) << WAIT_W) - CTRL_W'(1)) << WAIT_LSB;

  logic [WAIT_W-1:0] field;
  logic              wdata_unused;

  assign field        = wdata[WAIT_LSB +: WAIT_W];
  assign wdata_unused = ^(wdata & ~FIELD_MASK);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             waits[g] <= '0;
      else if (we && (sel == SEL_W'(g)))      waits[g] <= field;
    end
  end
endmodule

// File: rtl/wst_wait_sync.sv
module wst_wait_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_q_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q_n <= 1'b1;
    else        pin_q_n <= pin_n;
  end
endmodule

// File: rtl/wst_stall_seq.sv
module wst_stall_seq
  import wst_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic                          done,
  input  logic [NUM_CS-1:0]             hit,
  input  logic [NUM_CS-1:0][WAIT_W-1:0] waits,
  input  logic                          wait_q_n,
  output logic [NUM_CS-1:0]             cs_n,
  output logic                          stall,
  output logic                          start_evt,
  output logic                          end_evt,
  output logic                          cnt_zero,
  output logic [WAIT_W-1:0]             start_wait,
  output logic                          wait_armed
);
  // lowest set bit wins
  function automatic logic [SEL_W-1:0] first_hit(input logic [NUM_CS-1:0] v);
    logic [SEL_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (v[i]) idx = SEL_W'(i);
    end
    return idx;
  endfunction

  phase_t           phase;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic [WAIT_W-1:0] cnt;

  assign sel_d      = first_hit(hit);
  assign start_wait = waits[sel_d];
  assign start_evt  = (phase == PH_IDLE) && req && (|hit);
  assign end_evt    = (phase == PH_BUSY) && done;
  assign cnt_zero   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sel_q      <= '0;
      cnt        <= '0;
      wait_armed <= 1'b0;
    end else if (start_evt) begin
      phase      <= PH_BUSY;
      sel_q      <= sel_d;
      cnt        <= start_wait;
      wait_armed <= (start_wait != '0);
    end else if (end_evt) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      wait_armed <= 1'b0;
    end else if ((phase == PH_BUSY) && !cnt_zero) begin
      cnt        <= cnt - WAIT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !((phase == PH_BUSY) && (sel_q == SEL_W'(g)));
  end

  assign stall = (phase == PH_BUSY) && (!cnt_zero || (wait_armed && !wait_q_n));
endmodule

// File: rtl/wst_stall_ctrl.sv
module wst_stall_ctrl
  import wst_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned REG_W     = wst_pkg::CTRL_W,
  parameter int unsigned FIELD_LSB = wst_pkg::WAIT_LSB,
  parameter int unsigned FIELD_W   = wst_pkg::WAIT_W,
  localparam int unsigned SEL_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] cs_hit,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              wait_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [NUM_CS-1:0] cs_n,
  output logic              stall
);
  logic [NUM_CS-1:0][FIELD_W-1:0] waits;
  logic                           wait_q_n;
  logic                           io_req;
  logic                           strobes_idle;
  logic                           start_evt;
  logic                           end_evt;
  logic                           cnt_zero;
  logic [FIELD_W-1:0]             start_wait;
  logic                           wait_armed;

  assign io_req       = !iorq_n && (!rd_n || !wr_n);
  assign strobes_idle = rd_n && wr_n;

  wst_cfg_regs #(
    .NUM_CS(NUM_CS), .CTRL_W(REG_W), .WAIT_LSB(FIELD_LSB),
    .WAIT_W(FIELD_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
    .wdata(reg_wdata), .waits(waits)
  );

  wst_wait_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(wait_n), .pin_q_n(wait_q_n)
  );

  wst_stall_seq #(
    .NUM_CS(NUM_CS), .WAIT_W(FIELD_W), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(io_req), .done(strobes_idle),
    .hit(cs_hit), .waits(waits), .wait_q_n(wait_q_n),
    .cs_n(cs_n), .stall(stall), .start_evt(start_evt), .end_evt(end_evt),
    .cnt_zero(cnt_zero), .start_wait(start_wait), .wait_armed(wait_armed)
  );
endmodule

// File: rtl/wst_stall_ctrl_chk.sv
module wst_stall_ctrl_chk #(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iorq_n,
  input logic               rd_n,
  input logic               wr_n,
  input logic               wait_n,
  input logic [NUM_CS-1:0]  cs_n,
  input logic               stall,
  input logic               start_evt,
  input logic               cnt_zero,
  input logic [FIELD_W-1:0] start_wait,
  input logic               wait_armed
);
  logic active;
  assign active = !(&cs_n);

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_cnt_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cnt_zero) |-> stall);

  assert_zero_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && (start_wait == '0)) |=> !stall);

  assert_wait_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_zero && wait_armed) |-> (stall == !$past(wait_n)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_n && wr_n) |=> ((&cs_n) && !stall));

  assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(rd_n && wr_n)) |=> $stable(cs_n));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !start_evt);

  assert_io_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cs_n) && iorq_n) |=> (&cs_n));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !stall);
endmodule

bind wst_stall_ctrl wst_stall_ctrl_chk #(.NUM_CS(NUM_CS), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
  .wait_n(wait_n), .cs_n(cs_n), .stall(stall), .start_evt(start_evt),
  .cnt_zero(cnt_zero), .start_wait(start_wait), .wait_armed(wait_armed)
);

// File: tb/test_wst_stall_ctrl.sv
module test_wst_stall_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cs_hit = 4'h0;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, wait_n = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [3:0] cs_n;
  logic       stall;

  int checks = 0;
  int failures = 0;
  int shadow [4];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wst_stall_ctrl i_wst_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_hit(cs_hit), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .wait_n(wait_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cs_n(cs_n), .stall(stall)
  );

  function automatic int field_of(input logic [7:0] d);
    return (int'(d) / 32) % 8;
  endfunction

  function automatic int lowest(input logic [3:0] h);
    for (int i = 0; i < 4; i++) if (h[i]) return i;
    return 0;
  endfunction

  function automatic int exp_stall(input int w, input int ext);
    return (w == 0) ? 0 : w + ext;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow[idx] = field_of(d);
  endtask

  task automatic access(input logic [3:0] hit, input bit is_wr, input int ext, input string tag);
    int k, w, n;
    logic [3:0] exp_cs;
    k = lowest(hit);
    w = shadow[k];
    exp_cs = ~(4'b0001 << k);
    @(negedge clk);
    iorq_n = 1'b0; rd_n = is_wr; wr_n = !is_wr; cs_hit = hit;
    wait_n = (ext > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    check(cs_n == exp_cs, "R2", cs_n, exp_cs);
    cs_hit = 4'($urandom_range(0, 15)); // R8: ignored mid-access
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (!stall) break;
      n++;
      if (n >= w + ext) wait_n = 1'b1;
      @(negedge clk);
      check(cs_n == exp_cs, "R8", cs_n, exp_cs);
    end
    wait_n = 1'b1;
    check(n == exp_stall(w, ext), tag, n, exp_stall(w, ext));
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cs_hit = 4'h0;
    @(negedge clk);
    check((cs_n == 4'hF) && !stall, "R7", {cs_n, stall}, 5'h1E);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    check((cs_n == 4'hF) && !stall, "R1", {cs_n, stall}, 5'h1E);
    rst_n = 1'b1;
    @(negedge clk);
    check((cs_n == 4'hF) && !stall, "R1", {cs_n, stall}, 5'h1E);
    for (int i = 0; i < 4; i++) access(4'(1 << i), 1'b0, 2, "R1");

    // R9: no I/O request
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b0; cs_hit = 4'h4;
    repeat (2) @(negedge clk);
    check(cs_n == 4'hF, "R9", cs_n, 4'hF);
    rd_n = 1'b1; cs_hit = 4'h0;

    // R3: only bits [7:5] matter
    wr_reg(0, 8'h5F);  // field 2
    access(4'h1, 1'b0, 0, "R3");
    wr_reg(1, 8'hE0);  // field 7
    access(4'h2, 1'b1, 0, "R4");
    wr_reg(2, 8'h1F);  // field 0
    access(4'h4, 1'b0, 3, "R5");
    wr_reg(3, 8'h20);  // field 1, minimum for WAIT
    access(4'h8, 1'b1, 4, "R6");
    access(4'hC, 1'b0, 0, "R2");  // priority: index 2
    access(4'hA, 1'b1, 2, "R6");  // priority: index 1

    for (int it = 0; it < 250; it++) begin
      if ($urandom_range(0, 3) == 0) wr_reg($urandom_range(0, 3), 8'($urandom));
      begin
        logic [3:0] h;
        int e;
        h = 4'($urandom_range(1, 15));
        e = $urandom_range(0, 3);
        access(h, 1'($urandom), e, (shadow[lowest(h)] == 0) ? "R5" : ((e == 0) ? "R4" : "R6"));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule